// File: doc/BRIEF.md
# Non-volatile write permission and status unit

This block sits between a serial command decoder and a non-volatile array and decides whether each write request may go ahead. It holds a soft write-enable flag, a two-bit block-protect code, a lock bit that arms an external write-protect pin, and a busy flag driven by a self-timed write-cycle counter. The decoder pulses commands at it (set or clear the enable flag, stage and commit a status byte, commit an array write at a start address). The unit answers with one-cycle grant pulses and exposes the status byte for readout.

A state machine with three states orders the work. `ST_IDLE` accepts enable-flag commands, array commits and status staging. `ST_SR_PEND` holds a staged status byte until it is committed, rejected or cancelled. `ST_BUSY` runs the write timer. The transitions are: IDLE to BUSY on an accepted array commit. IDLE to SR_PEND on a staging pulse. SR_PEND to BUSY on an accepted commit. SR_PEND to IDLE on a rejected commit or on a falling edge of the protect pin. BUSY to IDLE when the timer expires. Protected regions are aligned to quarters of the address space and pages never straddle a quarter, so the start address alone decides a page write.

Top module: `nvw_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and busy is low.
- R2: In idle, a set pulse makes status bit1 (enable flag) read 1 and a clear pulse makes it read 0.
- R3: An array commit is granted (arr_grant_o high in the cycle after the commit edge) only when the enable flag is 1 and the address is outside the range picked by the protect code in status bits 3:2: 00 none, 01 addresses 0x1800-0x1FFF, 10 addresses 0x1000-0x1FFF, 11 all.
- R4: A rejected array commit gives no grant and no busy, and leaves the enable flag unchanged.
- R5: A status commit is granted only when the enable flag is 1 and not (lock bit status bit7 = 1 and wp_i = 0). A grant loads bits 7, 3 and 2 from the staged byte. Bits 6..4 and 1..0 of the staged byte have no effect.
- R6: A falling edge on wp_i while a status byte is staged cancels it. A later commit then gives no grant and the status is unchanged.
- R7: After any grant, busy_o is high for exactly WR_CYCLES clocks, and the status byte reads 0xFF during that time.
- R8: When busy ends, the enable flag reads 0.
- R9: Commands that arrive while busy are ignored. A status byte staged during busy cannot be committed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Set enable flag pulse |
| wel_clr_i | input | 1 | Clear enable flag pulse |
| sr_load_i | input | 1 | Stage status byte pulse |
| sr_data_i | input | 8 | Status byte to stage |
| sr_commit_i | input | 1 | Commit staged status byte pulse |
| arr_req_i | input | 1 | Array write commit pulse |
| arr_addr_i | input | AW | Array write start address |
| wp_i | input | 1 | Write-protect pin, low = protect |
| sr_grant_o | output | 1 | Status write granted pulse |
| arr_grant_o | output | 1 | Array write granted pulse |
| status_o | output | 8 | Status byte for readout |
| busy_o | output | 1 | Self-timed write in progress |

## Verification
The array path is swept over every protect code crossed with addresses on both sides of each quarter boundary, each with the enable flag off and on. This separates an off-by-one range compare and a wrong code decode from a missing enable gate. The status path is swept over all eight combinations of lock bit, pin level and enable flag, using a staged byte with all don't-care bits set. That pattern tells the pin lock apart from the enable gate and catches loads of bits that should be ignored. Busy length, the all-ones readout, the auto-clear, the cancellation by a pin fall and the commands ignored while busy are each driven once and observed at the ports.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SR_PEND = 2'd1,
        ST_BUSY    = 2'd2
    } nvw_state_e;
endpackage

// File: rtl/nvw_range_chk.sv
module nvw_range_chk (
    input  logic [1:0] bp_i,
    input  logic [1:0] quad_i,
    output logic       prot_o
);
    always_comb begin
        unique case (bp_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = (quad_i == 2'b11);
            2'b10:   prot_o = quad_i[1];
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvw_cycle_timer.sv
module nvw_cycle_timer #(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CW'(WR_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run_q && (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(cnt_q) < WR_CYCLES)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !done_o |-> !start_i); // R9
endmodule

// File: rtl/nvw_guard.sv
module nvw_guard
    import nvw_pkg::*;
#(
    parameter int AW        = 13,
    parameter int WR_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wel_set_i,
    input  logic          wel_clr_i,
    input  logic          sr_load_i,
    input  logic [7:0]    sr_data_i,
    input  logic          sr_commit_i,
    input  logic          arr_req_i,
    input  logic [AW-1:0] arr_addr_i,
    input  logic          wp_i,
    output logic          sr_grant_o,
    output logic          arr_grant_o,
    output logic [7:0]    status_o,
    output logic          busy_o
);
    localparam logic [7:0] BUSY_BYTE = 8'hFF;

    nvw_state_e state_q, state_d;
    logic       wel_q, wpen_q, pend_wpen_q, wp_q;
    logic [1:0] bp_q, pend_bp_q;
    logic       sr_grant_q, arr_grant_q;
    logic       prot, hw_lock, wp_fall, arr_ok, sr_ok, tmr_start, tmr_done;

    nvw_range_chk u_rng (
        .bp_i   (bp_q),
        .quad_i (arr_addr_i[AW-1:AW-2]),
        .prot_o (prot)
    );

    nvw_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    assign hw_lock   = wpen_q & ~wp_i;
    assign wp_fall   = wp_q & ~wp_i;
    assign arr_ok    = arr_req_i & wel_q & ~prot;
    assign sr_ok     = sr_commit_i & ~wp_fall & wel_q & ~hw_lock;
    assign tmr_start = ((state_q == ST_IDLE) && arr_ok) ||
                       ((state_q == ST_SR_PEND) && sr_ok);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arr_ok)         state_d = ST_BUSY;
                else if (!arr_req_i && sr_load_i)
                                    state_d = ST_SR_PEND;
            end
            ST_SR_PEND: begin
                if (wp_fall)        state_d = ST_IDLE;
                else if (sr_commit_i)
                                    state_d = sr_ok ? ST_BUSY : ST_IDLE;
            end
            ST_BUSY: begin
                if (tmr_done)       state_d = ST_IDLE;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    // state and register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wel_q       <= 1'b0;
            wpen_q      <= 1'b0;
            bp_q        <= 2'b00;
            pend_wpen_q <= 1'b0;
            pend_bp_q   <= 2'b00;
            wp_q        <= 1'b1;
            sr_grant_q  <= 1'b0;
            arr_grant_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            wp_q        <= wp_i;
            sr_grant_q  <= 1'b0;
            arr_grant_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (arr_req_i) begin
                        arr_grant_q <= arr_ok;
                    end else if (sr_load_i) begin
                        pend_wpen_q <= sr_data_i[7];
                        pend_bp_q   <= sr_data_i[3:2];
                    end else if (wel_set_i) begin
                        wel_q <= 1'b1;
                    end else if (wel_clr_i) begin
                        wel_q <= 1'b0;
                    end
                end
                ST_SR_PEND: begin
                    if (sr_ok) begin
                        wpen_q     <= pend_wpen_q;
                        bp_q       <= pend_bp_q;
                        sr_grant_q <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (tmr_done) wel_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // output process
    always_comb begin
        busy_o      = (state_q == ST_BUSY);
        sr_grant_o  = sr_grant_q;
        arr_grant_o = arr_grant_q;
        status_o    = busy_o ? BUSY_BYTE
                             : {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_grant_o, arr_grant_o})); // R3
    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant_o || arr_grant_o) |-> $past(wel_q)); // R3
    AST_NO_PROT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> !$past(prot)); // R3
    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant_o |-> !($past(wpen_q) && !$past(wp_i))); // R5
    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant_o || arr_grant_o) |-> busy_o); // R7
    AST_WEL_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_q); // R8
    AST_BP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(bp_q) && $stable(wpen_q)); // R9
endmodule

// File: tb/tb_nvw_guard.sv
module tb_nvw_guard;
    localparam int AW = 13;
    localparam int WRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wel_set = 0, wel_clr = 0, sr_load = 0, sr_commit = 0, arr_req = 0, wp = 1;
    logic [7:0] sr_data = '0;
    logic [AW-1:0] arr_addr = '0;
    logic sr_grant, arr_grant, busy;
    logic [7:0] status;
    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    nvw_guard #(.AW(AW), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .sr_load_i(sr_load), .sr_data_i(sr_data), .sr_commit_i(sr_commit),
        .arr_req_i(arr_req), .arr_addr_i(arr_addr), .wp_i(wp),
        .sr_grant_o(sr_grant), .arr_grant_o(arr_grant),
        .status_o(status), .busy_o(busy)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one pulse: inputs set after a falling edge, held across one rising edge
    task automatic cyc(input logic s, input logic c, input logic l, input logic cm,
                       input logic a, input logic [7:0] d, input logic [AW-1:0] ad);
        @(negedge clk);
        wel_set = s; wel_clr = c; sr_load = l; sr_commit = cm; arr_req = a;
        sr_data = d; arr_addr = ad;
        @(negedge clk);
        wel_set = 0; wel_clr = 0; sr_load = 0; sr_commit = 0; arr_req = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic prog(input logic [7:0] d);
        cyc(1, 0, 0, 0, 0, 8'h00, '0);
        cyc(0, 0, 1, 0, 0, d, '0);
        cyc(0, 0, 0, 1, 0, 8'h00, '0);
        wait_idle();
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] addrs [8];
        addrs = '{13'h0000, 13'h07FF, 13'h0800, 13'h0FFF,
                  13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R1", status, 8'h00);
        chk(busy == 1'b0, "R1", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2
        cyc(1, 0, 0, 0, 0, 8'h00, '0);
        chk(status[1] == 1'b1, "R2", status, 8'h02);
        cyc(0, 1, 0, 0, 0, 8'h00, '0);
        chk(status[1] == 1'b0, "R2", status, 8'h00);

        // R3 / R4 / R7 / R8 sweep
        for (int bp = 0; bp < 4; bp++) begin
            prog(8'(bp << 2));
            chk(status == 8'(bp << 2), "R5", status, bp << 2);
            for (int ai = 0; ai < 8; ai++) begin
                for (int w = 0; w < 2; w++) begin
                    int a;
                    logic prot, exp_g;
                    a = int'(addrs[ai]);
                    prot = (bp == 3) || (bp == 2 && a >= 'h1000) || (bp == 1 && a >= 'h1800);
                    exp_g = (w == 1) && !prot;
                    if (w == 1) cyc(1, 0, 0, 0, 0, 8'h00, '0);
                    cyc(0, 0, 0, 0, 1, 8'h00, addrs[ai]);
                    chk(arr_grant == exp_g, "R3", arr_grant, exp_g);
                    if (exp_g) begin
                        int nb;
                        nb = 0;
                        chk(status == 8'hFF, "R7", status, 8'hFF);
                        while (busy) begin nb++; @(negedge clk); end
                        chk(nb == WRC, "R7", nb, WRC);
                        chk(status == 8'(bp << 2), "R8", status, bp << 2);
                    end else begin
                        chk(busy == 1'b0, "R4", busy, 0);
                        chk(status == 8'((bp << 2) | (w << 1)), "R4", status, (bp << 2) | (w << 1));
                        if (w == 1) cyc(0, 1, 0, 0, 0, 8'h00, '0);
                    end
                end
            end
        end
        prog(8'h00);

        // R5 sweep: lock bit x pin x enable flag
        for (int k = 0; k < 8; k++) begin
            logic lk, pin, w, exp_g;
            logic [7:0] nd, exp_s;
            lk = k[2]; pin = k[1]; w = k[0];
            wp = 1'b1;
            prog({lk, 7'b0});
            wp = pin;
            @(negedge clk);
            if (w) cyc(1, 0, 0, 0, 0, 8'h00, '0);
            nd = {~lk, 3'b111, 2'b10, 2'b11};
            cyc(0, 0, 1, 0, 0, nd, '0);
            cyc(0, 0, 0, 1, 0, 8'h00, '0);
            exp_g = w && !(lk && !pin);
            chk(sr_grant == exp_g, "R5", sr_grant, exp_g);
            wait_idle();
            exp_s = exp_g ? {~lk, 3'b000, 2'b10, 2'b00} : {lk, 3'b000, 2'b00, w, 1'b0};
            chk(status == exp_s, "R5", status, exp_s);
            wp = 1'b1;
            @(negedge clk);
            if (status[1]) cyc(0, 1, 0, 0, 0, 8'h00, '0);
            prog(8'h00);
        end

        // R6: pin falls while a status byte is staged
        wp = 1'b1;
        cyc(1, 0, 0, 0, 0, 8'h00, '0);
        cyc(0, 0, 1, 0, 0, 8'h8C, '0);
        wp = 1'b0;
        @(negedge clk);
        cyc(0, 0, 0, 1, 0, 8'h00, '0);
        chk(sr_grant == 1'b0, "R6", sr_grant, 0);
        chk(status == 8'h02, "R6", status, 8'h02);
        wp = 1'b1;
        cyc(0, 1, 0, 0, 0, 8'h00, '0);

        // R9: staging during busy is dropped
        cyc(1, 0, 0, 0, 0, 8'h00, '0);
        cyc(0, 0, 0, 0, 1, 8'h00, 13'h0100);
        cyc(1, 0, 1, 0, 0, 8'h0C, '0);
        chk(busy == 1'b1, "R9", busy, 1);
        wait_idle();
        chk(status == 8'h00, "R9", status, 8'h00);
        cyc(0, 0, 0, 1, 0, 8'h00, '0);
        chk(sr_grant == 1'b0, "R9", sr_grant, 0);
        chk(status == 8'h00, "R9", status, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule